// File: doc/BRIEF.md
# Stereo Digital Attenuator

This block sets the playback volume of a stereo PCM stream in the digital domain. Each accepted frame carries a signed left and a signed right sample, plus one 6-bit attenuation code for each channel. A code of n asks for n decibels of cut, from 0 dB up to 63 dB. Each code addresses a gain table computed at elaboration, which holds the linear factor 10^(-n/20) in unsigned Q1.15. The sample is multiplied by that factor, rounded half-up back to sample width and clamped to the signed range.

The codes are captured in the same cycle as the sample they belong to. Code values presented between samples therefore have no effect. Both halves of a frame always use codes taken in one cycle, so no output frame can mix an old gain with a new one. Results leave two cycles after their sample arrives, with one shared valid strobe for both channels. Between results the outputs hold their last value.

Top module: `stereo_atten`

## Requirements
- R1: The two channels are independent: the left result depends only on the left sample and left code, and the right result only on the right sample and right code. A code value n (0 to 63) selects n dB of attenuation.
- R2: The gain for code n is round(32768 * 10^(-n/20)), an unsigned Q1.15 value. Code 0 gives 0x8000, which is exact unity. For an input sample of +32768 the output therefore equals the gain itself, and for -32768 it equals its negation.
- R3: Each result equals floor((s*g + 16384) / 32768), where s is the 24-bit two's-complement sample and g is the gain. This is rounding half toward plus infinity. The result is saturated to the range -8388608 to +8388607.
- R4: Code 0 returns every sample unchanged, including +8388607 and -8388608.
- R5: Codes are sampled only in cycles where in_valid is 1. Code values presented while in_valid is 0 do not change any output, including the next result.
- R6: Each result uses the codes presented in the same cycle as its own sample. This also holds when the codes change on every back-to-back frame.
- R7: out_valid is 1 exactly two clock cycles after each cycle with in_valid at 1, and 0 otherwise. Back-to-back inputs give back-to-back results.
- R8: out_left and out_right change only in cycles where out_valid is 1, and they hold their value otherwise.
- R9: While rst_n is low, out_valid is 0, both outputs are 0 and both held codes are 0. Any result still in flight is discarded.
- R10: The magnitude of a result never exceeds the magnitude of its input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample and codes are accepted this cycle |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| atten_left | input | 6 | Left attenuation code in dB |
| atten_right | input | 6 | Right attenuation code in dB |
| out_valid | output | 1 | Scaled frame is present on the outputs |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |

## Verification
Two things can happen in the same cycle: a new code is captured for the incoming sample, and the multiplier is still working on the previous sample with the code captured one cycle earlier. The bench provokes this with back-to-back frames whose codes change every cycle, and with left and right codes that differ. Each result is compared with a value the bench computes from that frame's own codes, so a gain taken one frame early or late, or taken from the other channel, shows up as a mismatch. The idle case is also covered: codes are changed while in_valid is low, and the bench checks that the held outputs and the next result ignore those values.

// File: rtl/atten_pkg.sv
package atten_pkg;

  localparam int NUM_CH   = 2;
  localparam int CH_LEFT  = 0;
  localparam int CH_RIGHT = 1;

  // Linear factor for a cut of 'step' dB, scaled by 2**frac and rounded.
  function automatic int db_gain(input int step, input int frac);
    real scale_v;
    real ratio;
    scale_v = 2.0 ** frac;
    ratio   = 10.0 ** (-real'(step) / 20.0);
    return $rtoi(scale_v * ratio + 0.5);
  endfunction

endpackage

// File: rtl/atten_gain_rom.sv
module atten_gain_rom #(
  parameter int CODE_W    = 6,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 15
) (
  input  logic [CODE_W-1:0] code,
  output logic [GAIN_W-1:0] gain
);
  localparam int DEPTH = 2 ** CODE_W;

  logic [GAIN_W-1:0] lut [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int GV = atten_pkg::db_gain(i, GAIN_FRAC);
    assign lut[i] = GV[GAIN_W-1:0];
  end

  assign gain = lut[code];
endmodule

// File: rtl/atten_scale.sv
module atten_scale #(
  parameter int SAMPLE_W  = 24,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 15
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [GAIN_W-1:0]   gain,
  output logic [SAMPLE_W-1:0] result
);
  localparam int PW = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] HALF =
    {{(PW-GAIN_FRAC){1'b0}}, 1'b1, {(GAIN_FRAC-1){1'b0}}};
  localparam logic signed [PW-1:0] HI =
    {{(PW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [PW-1:0] LO =
    {{(PW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

  logic signed [PW-1:0] s_ext, g_ext, prod, biased, shifted;

  always_comb begin
    s_ext   = PW'($signed(sample));
    g_ext   = PW'($signed({1'b0, gain}));
    prod    = s_ext * g_ext;
    biased  = prod + HALF;
    shifted = biased >>> GAIN_FRAC;
    if (shifted > HI)      result = HI[SAMPLE_W-1:0];
    else if (shifted < LO) result = LO[SAMPLE_W-1:0];
    else                   result = shifted[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/atten_lane.sv
module atten_lane #(
  parameter int SAMPLE_W  = 24,
  parameter int CODE_W    = 6,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                fire,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [CODE_W-1:0]   code,
  output logic [CODE_W-1:0]   code_q,
  output logic [SAMPLE_W-1:0] result_q
);
  logic [SAMPLE_W-1:0] sample_q;
  logic [GAIN_W-1:0]   gain;
  logic [SAMPLE_W-1:0] scaled;

  // Stage 1: the code and the sample are captured together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      sample_q <= '0;
    end else if (take) begin
      code_q   <= code;
      sample_q <= sample;
    end
  end

  atten_gain_rom #(.CODE_W(CODE_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_rom (
    .code (code_q),
    .gain (gain)
  );

  atten_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_scale (
    .sample (sample_q),
    .gain   (gain),
    .result (scaled)
  );

  // Stage 2: the result register updates only when a frame leaves
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    result_q <= '0;
    else if (fire) result_q <= scaled;
  end
endmodule

// File: rtl/stereo_atten.sv
module stereo_atten #(
  parameter int SAMPLE_W  = 24,
  parameter int CODE_W    = 6,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic [CODE_W-1:0]   atten_left,
  input  logic [CODE_W-1:0]   atten_right,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  localparam int NCH = atten_pkg::NUM_CH;

  logic                stage_valid;
  logic                code_take;
  logic                frame_fire;
  logic [SAMPLE_W-1:0] lane_in   [NCH];
  logic [CODE_W-1:0]   lane_code [NCH];
  logic [CODE_W-1:0]   lane_cq   [NCH];
  logic [SAMPLE_W-1:0] lane_out  [NCH];

  // Named internal events for the checker
  logic [CODE_W-1:0] code_q_left;
  logic [CODE_W-1:0] code_q_right;

  assign code_take  = in_valid;
  assign frame_fire = stage_valid;

  assign lane_in[atten_pkg::CH_LEFT]    = in_left;
  assign lane_in[atten_pkg::CH_RIGHT]   = in_right;
  assign lane_code[atten_pkg::CH_LEFT]  = atten_left;
  assign lane_code[atten_pkg::CH_RIGHT] = atten_right;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    atten_lane #(
      .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (code_take),
      .fire     (frame_fire),
      .sample   (lane_in[c]),
      .code     (lane_code[c]),
      .code_q   (lane_cq[c]),
      .result_q (lane_out[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_valid <= 1'b0;
      out_valid   <= 1'b0;
    end else begin
      stage_valid <= in_valid;
      out_valid   <= stage_valid;
    end
  end

  assign code_q_left  = lane_cq[atten_pkg::CH_LEFT];
  assign code_q_right = lane_cq[atten_pkg::CH_RIGHT];
  assign out_left     = lane_out[atten_pkg::CH_LEFT];
  assign out_right    = lane_out[atten_pkg::CH_RIGHT];
endmodule

// File: rtl/stereo_atten_chk.sv
module stereo_atten_chk #(
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_left,
  input logic [SAMPLE_W-1:0] in_right,
  input logic [CODE_W-1:0]   atten_left,
  input logic [CODE_W-1:0]   atten_right,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic [CODE_W-1:0]   code_q_left,
  input logic [CODE_W-1:0]   code_q_right
);
  function automatic logic [SAMPLE_W:0] mag(input logic [SAMPLE_W-1:0] v);
    logic [SAMPLE_W:0] e;
    e = {v[SAMPLE_W-1], v};
    return v[SAMPLE_W-1] ? (~e + 1'b1) : e;
  endfunction

  // R7: one result exactly two cycles after each accepted sample
  a_r7_latency_on: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  a_r7_latency_off: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  // R5: held codes move only on an accepted sample
  a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(code_q_left) && $stable(code_q_right)));
  // R6: both channels capture their codes in the sample's own cycle
  a_r6_code_take: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (code_q_left == $past(atten_left) && code_q_right == $past(atten_right)));

  // R8: outputs hold between results
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid || ($stable(out_left) && $stable(out_right))));

  // R4: code 0 passes the sample through
  a_r4_unity_left: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && atten_left == '0) |-> ##2 (out_left == $past(in_left, 2)));
  a_r4_unity_right: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && atten_right == '0) |-> ##2 (out_right == $past(in_right, 2)));

  // R10: attenuation never increases magnitude
  a_r10_no_gain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (mag(out_left) <= mag($past(in_left, 2)) &&
                   mag(out_right) <= mag($past(in_right, 2))));

  // R9: reset clears the valid strobe, outputs and held codes
  a_r9_reset: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_left == '0 && out_right == '0 &&
                code_q_left == '0 && code_q_right == '0) || !rst_n);
endmodule

bind stereo_atten stereo_atten_chk #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_left      (in_left),
  .in_right     (in_right),
  .atten_left   (atten_left),
  .atten_right  (atten_right),
  .out_valid    (out_valid),
  .out_left     (out_left),
  .out_right    (out_right),
  .code_q_left  (code_q_left),
  .code_q_right (code_q_right)
);

// File: tb/stereo_atten_test.sv
module stereo_atten_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic [5:0]  atten_left = '0, atten_right = '0;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] q_l [$];
  logic [23:0] q_r [$];
  string       q_tag [$];

  stereo_atten uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right),
    .atten_left(atten_left), .atten_right(atten_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  always #5 clk = ~clk;

  // Reference model, written from the requirements
  function automatic longint ref_gain(input int n);
    return longint'($rtoi(32768.0 * $pow(10.0, -n / 20.0) + 0.5));
  endfunction

  function automatic logic [23:0] ref_out(input logic [23:0] s, input int n);
    longint p, q;
    p = longint'($signed(s)) * ref_gain(n);
    q = (p + 64'sd16384) >>> 15;
    if (q > 64'sd8388607)  q = 64'sd8388607;
    if (q < -64'sd8388608) q = -64'sd8388608;
    return q[23:0];
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Result monitor: each result against the queued expectation
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_l.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 actual=unexpected result expected=none");
      end else begin
        string t;
        logic [23:0] el, er;
        t = q_tag.pop_front(); el = q_l.pop_front(); er = q_r.pop_front();
        check({t, " left"}, out_left, el);
        check({t, " right"}, out_right, er);
      end
    end
  end

  task automatic drive(input logic [23:0] l, input logic [23:0] r,
                       input int cl, input int cr, input string tag);
    in_valid = 1'b1; in_left = l; in_right = r;
    atten_left = 6'(cl); atten_right = 6'(cr);
    q_l.push_back(ref_out(l, cl)); q_r.push_back(ref_out(r, cr)); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req);
    idle(3);
    checks++;
    if (q_l.size() != 0) begin
      errors++;
      $display("FAIL %s actual=%0d pending expected=0", req, q_l.size());
      q_l.delete(); q_r.delete(); q_tag.delete();
    end
  endtask

  task automatic test_reset();
    check_bit("R9 valid", out_valid, 1'b0);
    check("R9 left", out_left, '0);
    check("R9 right", out_right, '0);
  endtask

  task automatic test_table();
    for (int n = 0; n < 64; n++) drive(24'd32768, -24'sd32768, n, n, "R2 table");
    drain("R2");
  endtask

  task automatic test_unity();
    drive(24'h7FFFFF, 24'h800000, 0, 0, "R4 extremes");
    drive(24'h000001, 24'hFFFFFF, 0, 0, "R4 small");
    drive(24'h123456, 24'hABCDEF, 0, 0, "R4 mixed");
    drain("R4");
  endtask

  task automatic test_rounding();
    drive(24'h000001, 24'hFFFFFF, 6, 6, "R3 tiny");
    drive(24'h7FFFFF, 24'h800000, 1, 1, "R3 full scale");
    drive(24'h800000, 24'h7FFFFF, 63, 63, "R3 max cut");
    drive(24'h000005, 24'hFFFFFB, 3, 3, "R3 half step");
    drive(24'h3A5C11, 24'hC5A3EF, 17, 40, "R10 R3 mixed");
    drain("R3");
  endtask

  task automatic test_independent();
    drive(24'h400000, 24'h400000, 0, 20, "R1 left unity right 20dB");
    drive(24'h400000, 24'h400000, 20, 0, "R1 left 20dB right unity");
    drive(24'h200000, 24'hE00000, 6, 12, "R1 split codes");
    drain("R1");
  endtask

  task automatic test_back_to_back();
    for (int i = 0; i < 16; i++)
      drive(24'(i * 24'h05A5A1), 24'(24'hF00000 + i * 24'h013579), i * 4, 63 - i * 3,
            "R6 R7 code per frame");
    drain("R7");
  endtask

  task automatic test_idle_codes();
    drive(24'h250000, 24'hD80000, 3, 7, "R5 before idle");
    idle(3);
    atten_left = 6'd40; atten_right = 6'd50;
    repeat (4) begin
      @(negedge clk);
      check("R8 R5 hold left", out_left, ref_out(24'h250000, 3));
      check("R8 R5 hold right", out_right, ref_out(24'hD80000, 7));
      check_bit("R7 idle valid", out_valid, 1'b0);
    end
    drive(24'h250000, 24'hD80000, 9, 11, "R5 after idle");
    drain("R5");
  endtask

  task automatic test_reset_midflight();
    drive(24'h111111, 24'h222222, 2, 2, "R9 in flight");
    rst_n = 1'b0;
    q_l.delete(); q_r.delete(); q_tag.delete();
    in_valid = 1'b0;
    @(negedge clk);
    test_reset();
    @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    idle(3);
    check_bit("R9 no late result", out_valid, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_table();
    test_unity();
    test_rounding();
    test_independent();
    test_back_to_back();
    test_idle_codes();
    test_reset_midflight();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule